// File: doc/BRIEF.md
# Multi-Port Sticky Status Register Bank

This block holds a set of sticky status registers for several ports. Each port owns a small group of 8-bit registers. A one-cycle pulse on an event input latches the matching bit, and the bit stays at 1 until software removes it. Software reaches the bank over a plain parallel register bus with an address, a write strobe, a read strobe, write data and registered read data.

A global control register sets how latched bits are removed, and the mode can change at run time. In write-one-to-clear mode, a write clears exactly the bits that carry a 1 in the data. This lets several software tasks share one register without disturbing each other's bits. In clear-on-read mode, a read returns the register and empties it in the same cycle. An event that lands during that read is kept, so it is never lost. A second control bit turns on broadcast: one status write then reaches the same register offset in every port. Read data is not meaningful while broadcast is on.

Top module: `sticky_status_bank`

## Requirements
- R1: After reset every status bit is 0, the control register is 0 (write-one-to-clear, broadcast off), and the read data output is 0.
- R2: An event pulse on input bit ((port*NREG + reg)*8 + b) sets bit b of that register at the next clock edge. A read issued in the following cycle returns it.
- R3: In write-one-to-clear mode, a write to a status register clears only the bits written with 1. Bits written with 0 keep their value.
- R4: The control register sits at address 0x10, where bit 0 selects clear-on-read and bit 1 turns on broadcast. It reads back these two bits, and all other bits read 0.
- R5: In clear-on-read mode, a read returns the register's value and clears the whole register at the same edge. An immediate second read returns 0.
- R6: In clear-on-read mode, an event arriving in the same cycle as a read of its register is not returned by that read. It is held in the register afterwards.
- R7: When an event and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R8: With broadcast on and write-one-to-clear mode, a status write to any port clears the written bits at that register offset in all ports.
- R9: In clear-on-read mode, writes to status registers have no effect.
- R10: Read data updates at the clock edge that samples the read strobe. It holds its value in every cycle that has no read.
- R11: A status address is {1'b0, port[1:0], reg[1:0]}. With broadcast off, an access changes only the addressed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| event_in | input | NPORT*NREG*8 | One-cycle event pulses, one per status bit |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Register address: status or control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
Every result of this block appears one edge after its stimulus. An event, a clear or a control write changes state at the first rising edge that samples it. Read data for a strobe also appears at that edge, and it holds the value from before any clear-on-read made at the same edge. The bench changes inputs on the falling edge and samples read data on the next falling edge. It advances its model at that point too, so each comparison lines up with the single register stage. Read data is not compared while broadcast is on.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  typedef struct packed {
    logic bcast;
    logic cor;
  } ctrl_t;

  function automatic logic [1:0] ctrl_bits(input ctrl_t c);
    return {c.bcast, c.cor};
  endfunction
endpackage

// File: rtl/ssb_ctrl.sv
module ssb_ctrl
  import ssb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [1:0] d,
  output ctrl_t      ctrl
);
  always_ff @(posedge clk) begin
    if (!rst_n) ctrl <= '0;
    else if (we) ctrl <= '{bcast: d[1], cor: d[0]};
  end
endmodule

// File: rtl/ssb_decode.sv
module ssb_decode #(
  parameter int NPORT = 4,
  parameter int NREG  = 4,
  parameter int PW    = 2,
  parameter int RW    = 2,
  parameter int AW    = PW + RW + 1,
  localparam int NCELL = NPORT * NREG
) (
  input  logic [AW-1:0]    addr,
  input  logic             wr,
  input  logic             rd,
  input  logic             cor,
  input  logic             bcast,
  output logic             ctrl_hit,
  output logic             stat_hit,
  output logic [NCELL-1:0] wsel,
  output logic [NCELL-1:0] rsel
);
  logic [PW-1:0] port;
  logic [RW-1:0] off;

  assign port     = addr[RW +: PW];
  assign off      = addr[0 +: RW];
  assign ctrl_hit = addr[AW-1] && (addr[AW-2:0] == '0);
  assign stat_hit = !addr[AW-1] && (int'(port) < NPORT);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic off_match, port_match;
      assign off_match  = stat_hit && (off == RW'(r));
      assign port_match = (port == PW'(p));
      assign wsel[p*NREG + r] = wr && !cor && off_match && (bcast || port_match);
      assign rsel[p*NREG + r] = rd && cor && off_match && port_match;
    end
  end
endmodule

// File: rtl/ssb_cell.sv
module ssb_cell #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         wsel,
  input  logic         rsel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q,
  output logic [W-1:0] clr
);
  function automatic logic [W-1:0] sticky_next(input logic [W-1:0] cur,
                                               input logic [W-1:0] c,
                                               input logic [W-1:0] s);
    return (cur & ~c) | s;
  endfunction

  assign clr = (wsel ? wdata : '0) | (rsel ? '1 : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= sticky_next(q, clr, set);
  end
endmodule

// File: rtl/sticky_status_bank.sv
module sticky_status_bank
  import ssb_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int NREG  = 4,
  parameter int W     = 8,
  localparam int PW    = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int RW    = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int AW    = PW + RW + 1,
  localparam int NCELL = NPORT * NREG,
  localparam int NB    = NCELL * W,
  localparam int IW    = PW + RW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] event_in,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata
);
  ctrl_t             ctrl;
  logic              cor_mode, bc_mode;
  logic              ctrl_hit, stat_hit;
  logic [NCELL-1:0]  wsel_vec, rsel_vec;
  logic [NB-1:0]     stat_flat, clr_flat;
  logic [W-1:0]      stat_arr [NCELL];
  logic [IW-1:0]     rd_idx;

  assign cor_mode = ctrl.cor;
  assign bc_mode  = ctrl.bcast;

  ssb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .we(bus_wr && ctrl_hit), .d(bus_wdata[1:0]), .ctrl(ctrl)
  );

  ssb_decode #(.NPORT(NPORT), .NREG(NREG), .PW(PW), .RW(RW), .AW(AW)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .cor(cor_mode), .bcast(bc_mode),
    .ctrl_hit(ctrl_hit), .stat_hit(stat_hit), .wsel(wsel_vec), .rsel(rsel_vec)
  );

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    ssb_cell #(.W(W)) u_cell (
      .clk(clk), .rst_n(rst_n),
      .set(event_in[i*W +: W]), .wsel(wsel_vec[i]), .rsel(rsel_vec[i]),
      .wdata(bus_wdata), .q(stat_flat[i*W +: W]), .clr(clr_flat[i*W +: W])
    );
    assign stat_arr[i] = stat_flat[i*W +: W];
  end

  assign rd_idx = IW'(int'(bus_addr[RW +: PW]) * NREG + int'(bus_addr[0 +: RW]));

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) begin
      if (ctrl_hit)      bus_rdata <= W'(ctrl_bits(ctrl));
      else if (stat_hit) bus_rdata <= stat_arr[rd_idx];
      else               bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/ssb_checker.sv
module ssb_checker #(
  parameter int NPORT = 4,
  parameter int NREG  = 4,
  parameter int W     = 8,
  localparam int NCELL = NPORT * NREG,
  localparam int NB    = NCELL * W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NB-1:0]    event_in,
  input logic [NB-1:0]    stat_flat,
  input logic [NB-1:0]    clr_flat,
  input logic [NCELL-1:0] wsel_vec,
  input logic             cor_mode,
  input logic             bc_mode,
  input logic             bus_rd,
  input logic [W-1:0]     bus_rdata
);
  // R2 / R7: a pulsed event is always present after the next edge
  p_event_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((stat_flat & $past(event_in)) == $past(event_in)));

  // R3: no bit rises without an event
  p_no_spurious_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (((stat_flat & ~$past(stat_flat)) & ~$past(event_in)) == '0));

  // R3: a bit falls only where a clear was applied
  p_fall_needs_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((($past(stat_flat) & ~stat_flat) & ~$past(clr_flat)) == '0));

  // R9: in clear-on-read mode nothing clears without a read
  p_cor_write_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cor_mode && !bus_rd) |-> (clr_flat == '0));

  // R10: read data holds when no read was sampled
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(bus_rd)) |-> $stable(bus_rdata));

  // R11: without broadcast at most one register takes a write clear
  p_single_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bc_mode |-> $onehot0(wsel_vec));
endmodule

bind sticky_status_bank ssb_checker #(.NPORT(NPORT), .NREG(NREG), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .event_in(event_in), .stat_flat(stat_flat),
  .clr_flat(clr_flat), .wsel_vec(wsel_vec), .cor_mode(cor_mode), .bc_mode(bc_mode),
  .bus_rd(bus_rd), .bus_rdata(bus_rdata)
);

// File: tb/tb_sticky_status_bank.sv
`timescale 1ns/1ps
module tb_sticky_status_bank;
  localparam int NP = 4, NR = 4, W = 8, AW = 5, NB = NP*NR*W;
  localparam logic [AW-1:0] CA = 5'h10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NB-1:0] ev = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  int n_run = 0, n_fail = 0;
  logic [W-1:0] m [NP][NR];
  logic m_cor = 1'b0, m_bc = 1'b0;

  always #4 clk = ~clk;

  sticky_status_bank #(.NPORT(NP), .NREG(NR), .W(W)) dut (
    .clk(clk), .rst_n(rst_n), .event_in(ev), .bus_wr(wr), .bus_rd(rd),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata)
  );

  function automatic logic [AW-1:0] sa(int p, int r);
    return {1'b0, 2'(p), 2'(r)};
  endfunction

  function automatic logic [NB-1:0] evb(int p, int r, logic [W-1:0] v);
    logic [NB-1:0] x = '0;
    x[(p*NR+r)*W +: W] = v;
    return x;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // one bus cycle; model advances at the edge, read data compared after it
  task automatic drive(input logic [NB-1:0] e, input logic we, input logic re,
                       input logic [AW-1:0] a, input logic [W-1:0] d, input string req);
    logic [W-1:0] er;
    logic ck;
    logic [W-1:0] nm [NP][NR];
    ck = re && !m_bc;
    if (a[4]) er = (a[3:0] == '0) ? {6'b0, m_bc, m_cor} : '0;
    else      er = m[a[3:2]][a[1:0]];
    for (int p = 0; p < NP; p++) begin
      for (int r = 0; r < NR; r++) begin
        logic [W-1:0] c;
        c = '0;
        if (we && !m_cor && !a[4] && int'(a[1:0]) == r && (m_bc || int'(a[3:2]) == p)) c = d;
        if (re && m_cor && !a[4] && int'(a[1:0]) == r && int'(a[3:2]) == p) c = '1;
        nm[p][r] = (m[p][r] & ~c) | e[(p*NR+r)*W +: W];
      end
    end
    ev = e; wr = we; rd = re; addr = a; wdata = d;
    @(negedge clk);
    m = nm;
    if (we && a == CA) begin m_cor = d[0]; m_bc = d[1]; end
    ev = '0; wr = 1'b0; rd = 1'b0;
    if (ck) check(req, rdata, er);
  endtask

  task automatic idle(); drive('0, 1'b0, 1'b0, '0, '0, ""); endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int p = 0; p < NP; p++) for (int r = 0; r < NR; r++) m[p][r] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    check("R1 rdata", rdata, 8'h00);
    for (int p = 0; p < NP; p++)
      for (int r = 0; r < NR; r++) drive('0, 1'b0, 1'b1, sa(p, r), '0, "R1");
    drive('0, 1'b0, 1'b1, CA, '0, "R1 ctrl");

    // R2 and R11
    drive(evb(1, 2, 8'h20), 1'b0, 1'b0, '0, '0, "");
    drive('0, 1'b0, 1'b1, sa(1, 2), '0, "R2");
    drive('0, 1'b0, 1'b1, sa(2, 2), '0, "R11");
    drive('0, 1'b0, 1'b1, sa(1, 1), '0, "R11");

    // R10: hold without a read, even when the register changes
    drive('0, 1'b0, 1'b1, sa(1, 2), '0, "R10");
    drive(evb(1, 2, 8'h01), 1'b0, 1'b0, '0, '0, "");
    idle();
    check("R10 hold", rdata, 8'h20);
    drive('0, 1'b0, 1'b1, sa(1, 2), '0, "R2");

    // R3 write-one-to-clear
    drive(evb(0, 0, 8'h0F), 1'b0, 1'b0, '0, '0, "");
    drive('0, 1'b1, 1'b0, sa(0, 0), 8'h05, "");
    drive('0, 1'b0, 1'b1, sa(0, 0), '0, "R3");
    // R7 set wins
    drive(evb(0, 0, 8'h01), 1'b1, 1'b0, sa(0, 0), 8'h0B, "");
    drive('0, 1'b0, 1'b1, sa(0, 0), '0, "R7");

    // R4 control register
    drive('0, 1'b1, 1'b0, CA, 8'hFD, "");
    drive('0, 1'b0, 1'b1, CA, '0, "R4");
    check("R4 value", rdata, 8'h01);

    // R5 clear-on-read
    drive(evb(3, 3, 8'h81), 1'b0, 1'b0, '0, '0, "");
    drive('0, 1'b0, 1'b1, sa(3, 3), '0, "R5");
    drive('0, 1'b0, 1'b1, sa(3, 3), '0, "R5");
    // R6 event during read
    drive(evb(2, 1, 8'h02), 1'b0, 1'b0, '0, '0, "");
    drive(evb(2, 1, 8'h40), 1'b0, 1'b1, sa(2, 1), '0, "R6");
    drive('0, 1'b0, 1'b1, sa(2, 1), '0, "R6");
    check("R6 kept", rdata, 8'h40);
    // R9 writes inert
    drive(evb(1, 0, 8'h33), 1'b0, 1'b0, '0, '0, "");
    drive('0, 1'b1, 1'b0, sa(1, 0), 8'hFF, "");
    drive('0, 1'b0, 1'b1, sa(1, 0), '0, "R9");

    // R8 broadcast clear
    drive('0, 1'b1, 1'b0, CA, 8'h02, "");
    drive(evb(0, 1, 8'hFF) | evb(1, 1, 8'hFF) | evb(2, 1, 8'hFF) | evb(3, 1, 8'hFF),
          1'b0, 1'b0, '0, '0, "");
    drive('0, 1'b1, 1'b0, sa(2, 1), 8'h0F, "");
    drive('0, 1'b1, 1'b0, CA, 8'h00, "");
    for (int p = 0; p < NP; p++) drive('0, 1'b0, 1'b1, sa(p, 1), '0, "R8");
    check("R8 value", rdata, 8'hF0);

    // constrained random mix
    for (int i = 0; i < 1500; i++) begin
      logic [NB-1:0] e;
      int op, p, r;
      for (int k = 0; k < NB/32; k++) e[k*32 +: 32] = $urandom & $urandom & $urandom & $urandom;
      op = int'($urandom % 100);
      p = int'($urandom % NP);
      r = int'($urandom % NR);
      if (op < 45)      drive(e, 1'b0, 1'b1, sa(p, r), '0, m_cor ? "R5" : "R3");
      else if (op < 75) drive(e, 1'b1, 1'b0, sa(p, r), W'($urandom), "R3");
      else if (op < 79) drive(e, 1'b1, 1'b0, CA, {6'b0, ($urandom % 4) == 0, 1'($urandom)}, "R4");
      else if (op < 82) drive(e, 1'b0, 1'b1, CA, '0, "R4");
      else              drive(e, 1'b0, 1'b0, '0, '0, "");
    end
    drive('0, 1'b1, 1'b0, CA, 8'h00, "");
    for (int p = 0; p < NP; p++)
      for (int r = 0; r < NR; r++) drive('0, 1'b0, 1'b1, sa(p, r), '0, "R3 final");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule